// File: doc/BRIEF.md
# Motion-Compensated Temporal Gradient Unit

This unit supplies the temporal derivative used by one refinement pass of a coarse-to-fine Lucas-Kanade flow estimator. Two on-chip frame stores sit inside it: one holds the current image and the other the reference image. A simple write port fills either store one pixel per cycle. Because the stores are separate, one can be refilled while the other keeps being read. Frames are loaded before a pass starts.

During a pass, the flow iteration stage streams in one pixel position per beat, together with that pixel's present displacement estimate. The unit shifts the position by the displacement in sub-pixel steps and clamps the result to the image. It then reads the 2x2 reference neighbourhood around the shifted point in a single cycle, from four banks chosen by row and column parity. A bilinear blend of those four pixels forms a prediction. The prediction is subtracted from the current pixel at the unshifted position.

The result leaves on a valid/ready stream, tagged with the pixel position it belongs to. When the consumer holds ready low, the whole four-stage pipeline freezes. The input ready then drops in the same cycle, so no beat is lost or reordered. Input ready depends combinationally on output ready.

Top module: `mctg_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 until a beat has been accepted.
- R2: With clamped coordinates (cx, cy) in sixteenths of a pixel, x0=cx/16, fx=cx%16, x1=min(x0+1,W-1), and likewise for y. The prediction is P = p00(16-fx)(16-fy) + p01·fx(16-fy) + p10(16-fx)fy + p11·fx·fy. Here p00=ref(x0,y0), p01=ref(x1,y0), p10=ref(x0,y1) and p11=ref(x1,y1). out_it equals cur(x,y)·16 − floor((P+8)/16), a two's-complement value with 4 fractional bits, and its magnitude never exceeds 4080.
- R3: in_u and in_v are signed two's-complement values with 4 fractional bits. The warped coordinate is cx = in_x·16 + in_u and cy = in_y·16 + in_v.
- R4: A warped coordinate below 0 is taken as 0. One beyond the last pixel, (W−1)·16 or (H−1)·16, is taken as that last pixel.
- R5: Without back-pressure, a beat accepted at a clock edge appears on out_valid/out_it exactly 4 clock edges later.
- R6: The unit accepts one beat per cycle. in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_it, out_x and out_y hold their values until the beat is taken.
- R8: out_x and out_y carry the in_x and in_y of the beat that produced out_it, and results leave in acceptance order.
- R9: A write with ld_en=1 stores ld_data at (ld_x, ld_y) on the next edge: into the current frame when ld_sel=0 and into the reference frame when ld_sel=1.
- R10: A displacement with zero fractional bits gives out_it = (cur(x,y) − ref(clamped x+u, clamped y+v))·16 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Frame store write strobe |
| ld_sel | input | 1 | Store select: 0 current frame, 1 reference frame |
| ld_x | input | XW | Write column |
| ld_y | input | YW | Write row |
| ld_data | input | PIX_W | Unsigned grayscale pixel to store |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_x | input | XW | Pixel column of the beat |
| in_y | input | YW | Pixel row of the beat |
| in_u | input | DISP_W | Horizontal displacement, signed, 4 fractional bits |
| in_v | input | DISP_W | Vertical displacement, signed, 4 fractional bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result when high |
| out_it | output | PIX_W+FRAC+1 | Temporal gradient, signed, 4 fractional bits |
| out_x | output | XW | Pixel column of the result |
| out_y | output | YW | Pixel row of the result |

## Verification
The properties assume that the frame stores are not written while beats are in flight. They also assume that the consumer never retracts a pending beat. Given that, the hold and latency checks rest only on the ready/valid handshake. The stimulus loads both frames fully while the stream is idle. Before the reference frame is reloaded, the stimulus waits for the pipeline to drain. Back-pressure is applied only by lowering out_ready. Displacements are drawn as integer, fractional and far out-of-range values, so the clamp paths at both edges of each axis are reached.

// File: rtl/mctg_pkg.sv
package mctg_pkg;
  typedef enum logic {
    TGT_CUR = 1'b0,
    TGT_REF = 1'b1
  } ld_tgt_e;
endpackage

// File: rtl/mctg_axis_warp.sv
module mctg_axis_warp #(
  parameter int N      = 16,
  parameter int PW     = 4,
  parameter int DISP_W = 10,
  parameter int FRAC   = 4
) (
  input  logic [PW-1:0]            pos,
  input  logic signed [DISP_W-1:0] disp,
  output logic [PW-1:0]            base,
  output logic [FRAC:0]            wt
);
  localparam int CW  = DISP_W + PW + 2;
  localparam int LIM = (N - 1) * (1 << FRAC);
  localparam logic signed [CW-1:0] LIM_S = CW'(LIM);

  logic signed [CW-1:0] pos_s;
  logic signed [CW-1:0] disp_s;
  logic signed [CW-1:0] crd;

  always_comb begin
    pos_s  = $signed({{(CW-PW-FRAC){1'b0}}, pos, {FRAC{1'b0}}});
    disp_s = $signed({{(CW-DISP_W){disp[DISP_W-1]}}, disp});
    crd    = pos_s + disp_s;
    if (crd[CW-1]) begin
      base = '0;
      wt   = '0;
    end else if (crd >= LIM_S) begin
      base = PW'(N - 2);
      wt   = (FRAC+1)'(1 << FRAC);
    end else begin
      base = crd[FRAC+PW-1:FRAC];
      wt   = {1'b0, crd[FRAC-1:0]};
    end
  end
endmodule

// File: rtl/mctg_ref_banks.sv
module mctg_ref_banks #(
  parameter int W     = 16,
  parameter int H     = 16,
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [$clog2(W)-1:0]    wr_x,
  input  logic [$clog2(H)-1:0]    wr_y,
  input  logic [PIX_W-1:0]        wr_data,
  input  logic                    rd_en,
  input  logic [$clog2(W)-1:0]    rd_x0,
  input  logic [$clog2(H)-1:0]    rd_y0,
  output logic [PIX_W-1:0]        p00,
  output logic [PIX_W-1:0]        p01,
  output logic [PIX_W-1:0]        p10,
  output logic [PIX_W-1:0]        p11
);
  localparam int XW   = $clog2(W);
  localparam int YW   = $clog2(H);
  localparam int BW   = W / 2;
  localparam int BH   = H / 2;
  localparam int BD   = BW * BH;
  localparam int BA_W = (BD > 1) ? $clog2(BD) : 1;

  logic [1:0]      wr_bank;
  logic [BA_W-1:0] wr_addr;
  logic [1:0]      par_q;
  logic [PIX_W-1:0] bank_q [4];

  assign wr_bank = {wr_y[0], wr_x[0]};
  assign wr_addr = BA_W'(wr_y >> 1) * BA_W'(BW) + BA_W'(wr_x >> 1);

  always_ff @(posedge clk) begin
    if (rd_en) par_q <= {rd_y0[0], rd_x0[0]};
  end

  for (genvar b = 0; b < 4; b++) begin : g_bank
    localparam int RP = b / 2;
    localparam int CP = b % 2;
    logic [PIX_W-1:0] mem [BD];
    logic [XW-1:0]    col;
    logic [YW-1:0]    row;
    logic [BA_W-1:0]  ra;
    logic [PIX_W-1:0] q;

    always_comb begin
      col = (rd_x0[0] == 1'(CP)) ? rd_x0 : rd_x0 + 1'b1;
      row = (rd_y0[0] == 1'(RP)) ? rd_y0 : rd_y0 + 1'b1;
      ra  = BA_W'(row >> 1) * BA_W'(BW) + BA_W'(col >> 1);
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == 2'(b)) mem[wr_addr] <= wr_data;
      if (rd_en) q <= mem[ra];
    end

    assign bank_q[b] = q;
  end

  assign p00 = bank_q[par_q];
  assign p01 = bank_q[{par_q[1], ~par_q[0]}];
  assign p10 = bank_q[{~par_q[1], par_q[0]}];
  assign p11 = bank_q[~par_q];
endmodule

// File: rtl/mctg_blend.sv
module mctg_blend #(
  parameter int PIX_W = 8,
  parameter int FRAC  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [PIX_W-1:0]              p00,
  input  logic [PIX_W-1:0]              p01,
  input  logic [PIX_W-1:0]              p10,
  input  logic [PIX_W-1:0]              p11,
  input  logic [FRAC:0]                 wx,
  input  logic [FRAC:0]                 wy,
  input  logic [PIX_W-1:0]              cur,
  output logic signed [PIX_W+FRAC:0]    it
);
  localparam int WT_W = FRAC + 1;
  localparam int HW   = PIX_W + FRAC;
  localparam int FW   = PIX_W + 2 * FRAC;
  localparam int IW   = PIX_W + FRAC + 1;
  localparam int ONE  = 1 << FRAC;

  logic [WT_W-1:0]  iwx, iwy;
  logic [HW-1:0]    h_top, h_bot, top_q, bot_q;
  logic [WT_W-1:0]  wy_q;
  logic [PIX_W-1:0] cur_q;
  logic [FW-1:0]    full;
  logic [FW:0]      rnd;
  logic [IW-1:0]    pred;
  logic signed [IW-1:0] it_d;

  always_comb begin
    iwx   = WT_W'(ONE) - wx;
    h_top = HW'(p00) * HW'(iwx) + HW'(p01) * HW'(wx);
    h_bot = HW'(p10) * HW'(iwx) + HW'(p11) * HW'(wx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
      wy_q  <= '0;
      cur_q <= '0;
    end else if (en) begin
      top_q <= h_top;
      bot_q <= h_bot;
      wy_q  <= wy;
      cur_q <= cur;
    end
  end

  always_comb begin
    iwy  = WT_W'(ONE) - wy_q;
    full = FW'(top_q) * FW'(iwy) + FW'(bot_q) * FW'(wy_q);
    rnd  = (FW+1)'(full) + (FW+1)'(ONE / 2);
    pred = rnd[FW:FRAC];
    it_d = $signed({1'b0, cur_q, {FRAC{1'b0}}}) - $signed(pred);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  it <= '0;
    else if (en) it <= it_d;
  end
endmodule

// File: rtl/mctg_unit.sv
module mctg_unit
  import mctg_pkg::*;
#(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 16,
  parameter int PIX_W  = 8,
  parameter int FRAC   = 4,
  parameter int DISP_W = 10,
  localparam int XW    = $clog2(IMG_W),
  localparam int YW    = $clog2(IMG_H),
  localparam int IT_W  = PIX_W + FRAC + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic                     ld_sel,
  input  logic [XW-1:0]            ld_x,
  input  logic [YW-1:0]            ld_y,
  input  logic [PIX_W-1:0]         ld_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [XW-1:0]            in_x,
  input  logic [YW-1:0]            in_y,
  input  logic signed [DISP_W-1:0] in_u,
  input  logic signed [DISP_W-1:0] in_v,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [IT_W-1:0]   out_it,
  output logic [XW-1:0]            out_x,
  output logic [YW-1:0]            out_y
);
  localparam int WT_W = FRAC + 1;
  localparam int CA_W = $clog2(IMG_W * IMG_H);

  logic adv;
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  // stage 0: warp and clamp each axis
  logic [XW-1:0]   bx;
  logic [YW-1:0]   by;
  logic [WT_W-1:0] wx, wy;

  mctg_axis_warp #(.N(IMG_W), .PW(XW), .DISP_W(DISP_W), .FRAC(FRAC)) u_warp_x (
    .pos(in_x), .disp(in_u), .base(bx), .wt(wx)
  );
  mctg_axis_warp #(.N(IMG_H), .PW(YW), .DISP_W(DISP_W), .FRAC(FRAC)) u_warp_y (
    .pos(in_y), .disp(in_v), .base(by), .wt(wy)
  );

  // stage 1 registers
  logic            s1_v;
  logic [XW-1:0]   s1_bx, s1_x;
  logic [YW-1:0]   s1_by, s1_y;
  logic [WT_W-1:0] s1_wx, s1_wy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_bx <= '0;
      s1_by <= '0;
      s1_x  <= '0;
      s1_y  <= '0;
      s1_wx <= '0;
      s1_wy <= '0;
    end else if (adv) begin
      s1_v  <= in_valid;
      s1_bx <= bx;
      s1_by <= by;
      s1_x  <= in_x;
      s1_y  <= in_y;
      s1_wx <= wx;
      s1_wy <= wy;
    end
  end

  // stage 2: parallel neighbourhood fetch and current pixel read
  logic [PIX_W-1:0] p00, p01, p10, p11;
  logic [PIX_W-1:0] cur_mem [IMG_W*IMG_H];
  logic [PIX_W-1:0] cur_q;
  logic [CA_W-1:0]  cur_wa, cur_ra;

  mctg_ref_banks #(.W(IMG_W), .H(IMG_H), .PIX_W(PIX_W)) u_ref (
    .clk     (clk),
    .wr_en   (ld_en && (ld_sel == TGT_REF)),
    .wr_x    (ld_x),
    .wr_y    (ld_y),
    .wr_data (ld_data),
    .rd_en   (adv),
    .rd_x0   (s1_bx),
    .rd_y0   (s1_by),
    .p00     (p00),
    .p01     (p01),
    .p10     (p10),
    .p11     (p11)
  );

  assign cur_wa = CA_W'(ld_y) * CA_W'(IMG_W) + CA_W'(ld_x);
  assign cur_ra = CA_W'(s1_y) * CA_W'(IMG_W) + CA_W'(s1_x);

  always_ff @(posedge clk) begin
    if (ld_en && (ld_sel == TGT_CUR)) cur_mem[cur_wa] <= ld_data;
    if (adv) cur_q <= cur_mem[cur_ra];
  end

  logic            s2_v, s3_v, s4_v;
  logic [XW-1:0]   s2_x, s3_x, s4_x;
  logic [YW-1:0]   s2_y, s3_y, s4_y;
  logic [WT_W-1:0] s2_wx, s2_wy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s3_v <= 1'b0; s4_v <= 1'b0;
      s2_x <= '0;   s3_x <= '0;   s4_x <= '0;
      s2_y <= '0;   s3_y <= '0;   s4_y <= '0;
      s2_wx <= '0;  s2_wy <= '0;
    end else if (adv) begin
      s2_v <= s1_v; s2_x <= s1_x; s2_y <= s1_y;
      s2_wx <= s1_wx; s2_wy <= s1_wy;
      s3_v <= s2_v; s3_x <= s2_x; s3_y <= s2_y;
      s4_v <= s3_v; s4_x <= s3_x; s4_y <= s3_y;
    end
  end

  // stages 3 and 4: bilinear blend and difference
  mctg_blend #(.PIX_W(PIX_W), .FRAC(FRAC)) u_blend (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .p00   (p00),
    .p01   (p01),
    .p10   (p10),
    .p11   (p11),
    .wx    (s2_wx),
    .wy    (s2_wy),
    .cur   (cur_q),
    .it    (out_it)
  );

  assign out_valid = s4_v;
  assign out_x     = s4_x;
  assign out_y     = s4_y;
endmodule

// File: rtl/mctg_unit_chk.sv
module mctg_unit_chk #(
  parameter int XW    = 4,
  parameter int YW    = 4,
  parameter int PIX_W = 8,
  parameter int FRAC  = 4,
  parameter int IT_W  = 13
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic signed [IT_W-1:0] out_it,
  input logic [XW-1:0]          out_x,
  input logic [YW-1:0]          out_y
);
  localparam logic signed [IT_W-1:0] MAXIT = IT_W'(((1 << PIX_W) - 1) << FRAC);

  logic       acc, dlv;
  logic [3:0] inflight;
  logic [2:0] cyc;

  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
      cyc      <= '0;
    end else begin
      inflight <= inflight + 4'(acc) - 4'(dlv);
      if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end
  end

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_it) && $stable(out_x) && $stable(out_y))); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_IT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_it <= MAXIT && out_it >= -MAXIT)); // R2

  AST_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'd4); // R5

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && $past(acc, 4) && $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3))
      |-> out_valid); // R5
endmodule

bind mctg_unit mctg_unit_chk #(
  .XW(XW), .YW(YW), .PIX_W(PIX_W), .FRAC(FRAC), .IT_W(IT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_it(out_it),
  .out_x(out_x), .out_y(out_y)
);

// File: tb/mctg_unit_test.sv
`timescale 1ns/1ps
module mctg_unit_test;
  localparam int W = 16;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, ld_sel = 1'b0;
  logic [3:0] ld_x = '0, ld_y = '0;
  logic [7:0] ld_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [3:0] in_x = '0, in_y = '0;
  logic signed [9:0] in_u = '0, in_v = '0;
  logic out_valid, out_ready = 1'b1;
  logic signed [12:0] out_it;
  logic [3:0] out_x, out_y;

  mctg_unit uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_x(ld_x),
    .ld_y(ld_y), .ld_data(ld_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_u(in_u), .in_v(in_v), .out_valid(out_valid),
    .out_ready(out_ready), .out_it(out_it), .out_x(out_x), .out_y(out_y)
  );

  always #2.5 clk = ~clk;

  int nchecks = 0, nerr = 0;
  int cur_m [W][H];
  int ref_m [W][H];
  logic [31:0] lcg = 32'h1234_5678;
  bit bp_on = 1'b0;
  bit checking = 1'b0;
  string tag_in = "R2";

  // behavioural model: four slots, shifted whenever the consumer is not stalling
  int    m_v [4], m_it [4], m_x [4], m_y [4];
  string m_tag [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg[30:8]);
  endfunction

  function automatic int exp_it(input int px, input int py, input int u, input int v);
    int cx, cy, x0, x1, y0, y1, fx, fy, p;
    cx = px * 16 + u;
    cy = py * 16 + v;
    if (cx < 0) cx = 0;
    if (cx > (W - 1) * 16) cx = (W - 1) * 16;
    if (cy < 0) cy = 0;
    if (cy > (H - 1) * 16) cy = (H - 1) * 16;
    x0 = cx / 16; fx = cx % 16; x1 = (x0 + 1 > W - 1) ? W - 1 : x0 + 1;
    y0 = cy / 16; fy = cy % 16; y1 = (y0 + 1 > H - 1) ? H - 1 : y0 + 1;
    p = ref_m[x0][y0] * (16 - fx) * (16 - fy) + ref_m[x1][y0] * fx * (16 - fy)
      + ref_m[x0][y1] * (16 - fx) * fy + ref_m[x1][y1] * fx * fy;
    return cur_m[px][py] * 16 - (p + 8) / 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_v[i] = 0;
    end else if (!(m_v[3] != 0 && !out_ready)) begin
      for (int i = 3; i > 0; i--) begin
        m_v[i] = m_v[i-1]; m_it[i] = m_it[i-1];
        m_x[i] = m_x[i-1]; m_y[i] = m_y[i-1]; m_tag[i] = m_tag[i-1];
      end
      m_v[0] = in_valid ? 1 : 0;
      if (in_valid) begin
        m_it[0] = exp_it(int'(in_x), int'(in_y), int'(in_u), int'(in_v));
        m_x[0] = int'(in_x); m_y[0] = int'(in_y); m_tag[0] = tag_in;
      end
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(int'(out_valid) == m_v[3], "R5 valid timing", int'(out_valid), m_v[3]);
      chk(int'(in_ready) == ((m_v[3] != 0 && !out_ready) ? 0 : 1),
          (m_v[3] != 0 && !out_ready) ? "R7 ready under stall" : "R6 ready",
          int'(in_ready), (m_v[3] != 0 && !out_ready) ? 0 : 1);
      if (m_v[3] != 0 && out_valid) begin
        chk(int'(out_it) == m_it[3], m_tag[3], int'(out_it), m_it[3]);
        chk(int'(out_x) == m_x[3] && int'(out_y) == m_y[3], "R8 index",
            int'(out_x) * 16 + int'(out_y), m_x[3] * 16 + m_y[3]);
      end
    end
  end

  task automatic load(input bit sel, input int x, input int y, input int d);
    @(negedge clk); #1;
    ld_en = 1'b1; ld_sel = sel; ld_x = 4'(x); ld_y = 4'(y); ld_data = 8'(d);
    if (sel) ref_m[x][y] = d; else cur_m[x][y] = d;
  endtask

  task automatic step(input bit v, input int x, input int y, input int u, input int dv, input string tg);
    forever begin
      @(negedge clk); #1;
      ld_en = 1'b0;
      out_ready = bp_on ? (rnd() % 3 != 0) : 1'b1;
      in_valid = v; in_x = 4'(x); in_y = 4'(y);
      in_u = 10'(u); in_v = 10'(dv); tag_in = tg;
      #1;
      if (!v || in_ready) break;
    end
  endtask

  task automatic drain();
    bit keep;
    keep = bp_on;
    bp_on = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 0, 0, "R2");
    bp_on = keep;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R6 watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R9: fill both stores through the load port
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        load(1'b0, x, y, (x * 7 + y * 13 + 3) % 256);
        load(1'b1, x, y, (x * 11 + y * 5 + x * y * 3 + 17) % 256);
      end
    checking = 1'b1;

    // R9 / R6: zero displacement, back-to-back stream
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) step(1'b1, x, y, 0, 0, "R9 zero warp");
    drain();

    // R10: integer displacements
    for (int i = 0; i < 120; i++)
      step(1'b1, rnd() % W, rnd() % H, ((rnd() % 9) - 4) * 16, ((rnd() % 9) - 4) * 16, "R10 integer warp");
    drain();

    // R2 / R3: fractional displacements
    for (int i = 0; i < 300; i++)
      step(1'b1, rnd() % W, rnd() % H, (rnd() % 400) - 200, (rnd() % 400) - 200, "R2 R3 subpixel blend");
    drain();

    // R4: far outside on every side, plus exact last-pixel edges
    for (int i = 0; i < 100; i++)
      step(1'b1, rnd() % W, rnd() % H, (i % 2 != 0) ? 300 + rnd() % 200 : -300 - rnd() % 200,
           (i % 4 < 2) ? 511 : -512, "R4 clamp far");
    step(1'b1, 15, 15, 0, 0, "R4 last pixel");
    step(1'b1, 14, 14, 16, 16, "R4 edge reach");
    step(1'b1, 15, 0, 8, -8, "R4 corner");
    step(1'b1, 0, 15, -1, 1, "R4 corner");
    drain();

    // R7: random back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 400; i++)
      step(1'b1, rnd() % W, rnd() % H, (rnd() % 600) - 300, (rnd() % 600) - 300, "R7 stalled blend");
    drain();
    bp_on = 1'b0;

    // R9: reload the reference store while idle, then stream again
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) load(1'b1, x, y, (x * x + y * 29 + 90) % 256);
    for (int i = 0; i < 200; i++)
      step(1'b1, rnd() % W, rnd() % H, (rnd() % 300) - 150, (rnd() % 300) - 150, "R9 reloaded ref");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule